// File: doc/BRIEF.md
# Two-Byte-Address Serial EEPROM Slave Controller

This block is the byte-level slave engine of an 8K x 8 serial EEPROM that uses a two-byte memory address on an I2C bus. A line front end hands it one-cycle pulses for start, stop, SCL rising and SCL falling, plus the filtered SDA level. The controller decodes the device byte, collects the two address bytes, accepts write data, serves reads from a memory read port and drives an open-drain SDA pull-down enable.

Accepted write bytes leave as address/data strobes for a neighbouring page write engine. A commit strobe at stop starts the non-volatile cycle in that engine. The block also keeps the current-address counter, which current-address reads and sequential reads use.

Top module: `ee2a_slave_ctrl`

## Requirements
- R1: A device byte (MSB first) is accepted only when bits 7:4 equal 4'b1010 and bits 3:1 equal `sel_i`. Any other device byte gets no acknowledge, and the block ignores the bus until the next start.
- R2: Bit 0 of the device byte selects the direction: 1 starts a read, 0 starts a write header.
- R3: A write header carries a high address byte and then a low address byte. The address becomes {high[4:0], low}, and high-byte bits 7:5 are ignored.
- R4: An acknowledge asserts `sda_oe_o`=1 (SDA pulled low) from the SCL fall after the 8th bit to the SCL fall after the 9th bit. After that fall the line is released.
- R5: Every accepted data byte gives a one-cycle `wr_we_o` with its address and data. A stop after at least one accepted byte gives exactly one `wr_commit_o` pulse.
- R6: During a write the address advances only in its 5 low bits, so it wraps inside the 32-byte page.
- R7: A current-address read returns the byte at the last accessed address plus one, whether that access was a read or a write.
- R8: A random read is a write header, then a repeated start, then a read device byte. It returns data from the loaded address.
- R9: Each master acknowledge on a read byte sends the next byte. The read address advances over all 13 bits and wraps from 0x1FFF to 0x0000.
- R10: A master no-acknowledge ends the read, and SDA stays released until the next start.
- R11: With `wp_i` high, the device byte and both address bytes are acknowledged. No data byte is acknowledged, and no write strobe and no commit are issued.
- R12: While `busy_i` is high, the device byte is not acknowledged.
- R13: `sda_oe_o` changes only in the cycle after an SCL fall, start or stop.
- R14: A start at any point restarts the device-byte phase. A stop ends the transaction, and a partial byte never reaches the write engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition pulse |
| stop_i | input | 1 | Stop condition pulse |
| scl_rise_i | input | 1 | SCL rising edge pulse |
| scl_fall_i | input | 1 | SCL falling edge pulse |
| sda_i | input | 1 | Filtered SDA level |
| sel_i | input | 3 | Device select strap |
| wp_i | input | 1 | Write protect |
| busy_i | input | 1 | Write engine busy |
| sda_oe_o | output | 1 | SDA pull-down enable |
| rd_addr_o | output | 13 | Read port address (current-address counter) |
| rd_data_i | input | 8 | Read port data, valid in the same cycle |
| wr_we_o | output | 1 | Write data strobe |
| wr_addr_o | output | 13 | Write byte address |
| wr_data_o | output | 8 | Write byte data |
| wr_commit_o | output | 1 | Start non-volatile cycle |

## Verification
The bench starts a page write two bytes before the page end. A design that carried into bit 5 would place the third byte at 0x0040 instead of 0x0020. A sequential read is run across 0x1FFF, where a page-limited read counter would return data from 0x1FE0 rather than 0x0000. Write protect is checked to acknowledge both address bytes yet refuse data; a design that protected too early would drop the address acknowledges, and one that protected too late would emit write strobes. A start is also issued in the middle of a byte, which would corrupt the next header if the bit counter were not cleared.

// File: rtl/ee2a_pkg.sv
package ee2a_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_RDAT} st_e;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/ee2a_bitcnt.sv
module ee2a_bitcnt #(
  parameter int BYTE_W = 8,
  localparam int CW = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              sda_i,
  output logic [CW-1:0]     cnt_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic              ack_slot_o
);
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (start_i || stop_i) begin
      cnt_q <= '0;
    end else if (scl_rise_i) begin
      sh_q  <= {sh_q[BYTE_W-3:0], sda_i};
      cnt_q <= (cnt_q == CW'(BYTE_W)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o       = cnt_q;
  assign byte_o      = {sh_q, sda_i};
  assign byte_done_o = scl_rise_i && !start_i && !stop_i && cnt_q == CW'(BYTE_W - 1);
  assign ack_slot_o  = scl_rise_i && !start_i && !stop_i && cnt_q == CW'(BYTE_W);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(BYTE_W)); // R4
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_q == '0); // R14
endmodule

// File: rtl/ee2a_addr_ctr.sv
module ee2a_addr_ctr #(
  parameter int AW = 13,
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_page_i,
  input  logic          inc_full_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         addr_q <= '0;
    else if (load_i)     addr_q <= load_val_i;
    else if (inc_full_i) addr_q <= addr_q + 1'b1;
    else if (inc_page_i) addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
  end

  assign addr_o = addr_q;

  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_page_i && !load_i && !inc_full_i) |=> addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])); // R6
  AST_FULL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_full_i && !load_i && addr_q == '1) |=> addr_q == '0); // R9
endmodule

// File: rtl/ee2a_slave_ctrl.sv
module ee2a_slave_ctrl
  import ee2a_pkg::*;
#(
  parameter int AW = 13,
  parameter int PAGE_W = 5,
  localparam int HI_W = AW - 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_i,
  input  logic [2:0]    sel_i,
  input  logic          wp_i,
  input  logic          busy_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          wr_we_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);
  st_e            st_q;
  logic [3:0]     bit_cnt;
  logic [7:0]     rx_byte;
  logic           byte_done, ack_slot;
  logic           ack_q, oe_q, oe_nxt, data_seen_q;
  logic [HI_W-1:0] hi_q;
  logic [AW-1:0]  cur_addr;
  logic           ctr_load, ctr_inc_page, ctr_inc_full, dev_match;

  ee2a_bitcnt #(.BYTE_W(8)) u_bitcnt (
    .clk_i, .rst_ni, .start_i, .stop_i, .scl_rise_i, .sda_i,
    .cnt_o(bit_cnt), .byte_o(rx_byte), .byte_done_o(byte_done), .ack_slot_o(ack_slot)
  );

  assign ctr_load     = byte_done && st_q == ST_ALO;
  assign ctr_inc_page = byte_done && st_q == ST_WDAT && !wp_i;
  assign ctr_inc_full = byte_done && st_q == ST_RDAT;

  ee2a_addr_ctr #(.AW(AW), .PW(PAGE_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(ctr_load), .load_val_i({hi_q, rx_byte}),
    .inc_page_i(ctr_inc_page), .inc_full_i(ctr_inc_full),
    .addr_o(cur_addr)
  );

  assign dev_match = rx_byte[7:4] == DEV_TYPE && rx_byte[3:1] == sel_i && !busy_i;

  // Ack slot uses ack_q; read bits come straight from the read port.
  always_comb begin
    oe_nxt = 1'b0;
    if (bit_cnt == 4'd8)      oe_nxt = ack_q;
    else if (st_q == ST_RDAT) oe_nxt = ~rd_data_i[~bit_cnt[2:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ack_q       <= 1'b0;
      oe_q        <= 1'b0;
      data_seen_q <= 1'b0;
      hi_q        <= '0;
      wr_we_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_we_o     <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_i) begin
        st_q        <= ST_DEV;
        ack_q       <= 1'b0;
        oe_q        <= 1'b0;
        data_seen_q <= 1'b0;
      end else if (stop_i) begin
        st_q        <= ST_IDLE;
        ack_q       <= 1'b0;
        oe_q        <= 1'b0;
        data_seen_q <= 1'b0;
        wr_commit_o <= st_q == ST_WDAT && data_seen_q;
      end else begin
        if (byte_done) begin
          unique case (st_q)
            ST_DEV: begin
              ack_q <= dev_match;
              st_q  <= !dev_match ? ST_IDLE : (rx_byte[0] ? ST_RDAT : ST_AHI);
            end
            ST_AHI: begin
              hi_q  <= rx_byte[HI_W-1:0];
              ack_q <= 1'b1;
              st_q  <= ST_ALO;
            end
            ST_ALO: begin
              ack_q <= 1'b1;
              st_q  <= ST_WDAT;
            end
            ST_WDAT: begin
              if (wp_i) begin
                ack_q <= 1'b0;
                st_q  <= ST_IDLE;
              end else begin
                ack_q       <= 1'b1;
                wr_we_o     <= 1'b1;
                wr_addr_o   <= cur_addr;
                wr_data_o   <= rx_byte;
                data_seen_q <= 1'b1;
              end
            end
            default: ack_q <= 1'b0;
          endcase
        end
        if (ack_slot && st_q == ST_RDAT && !ack_q && sda_i) st_q <= ST_IDLE;
        if (scl_fall_i) oe_q <= oe_nxt;
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign rd_addr_o = cur_addr;

  AST_OE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(sda_oe_o)); // R13
  AST_BUSY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !start_i && !stop_i && st_q == ST_DEV && busy_i) |=> !ack_q); // R12
  AST_WP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_we_o |-> !$past(wp_i)); // R11
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o); // R5
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R14
endmodule

// File: tb/ee2a_slave_ctrl_tb.sv
module ee2a_slave_ctrl_tb;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, scl_rise_i = 0, scl_fall_i = 0;
  logic m_sda = 1'b1, wp_i = 0, busy_i = 0;
  logic sda_oe, wr_we, wr_commit, line;
  logic [12:0] rd_addr, wr_addr;
  logic [7:0]  rd_data, wr_data;
  int n_chk = 0, n_fail = 0, lg_n = 0, commit_n = 0;
  logic [12:0] lg_a [0:15];
  logic [7:0]  lg_d [0:15];
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction

  assign line    = m_sda & ~sda_oe;
  assign rd_data = mem_f(rd_addr);

  ee2a_slave_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .stop_i, .scl_rise_i, .scl_fall_i,
    .sda_i(line), .sel_i(SEL), .wp_i, .busy_i, .sda_oe_o(sda_oe),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .wr_we_o(wr_we),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  always @(posedge clk) begin
    if (wr_we && lg_n < 16) begin
      lg_a[lg_n] <= wr_addr;
      lg_d[lg_n] <= wr_data;
      lg_n <= lg_n + 1;
    end
    if (wr_commit) commit_n <= commit_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; tick(2);
    scl_rise_i = 1; tick(1); scl_rise_i = 0; tick(2);
    s = line;
    scl_fall_i = 1; tick(1); scl_fall_i = 0; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      b = {b[6:0], s};
    end
    bit_io(!mack, s);
    m_sda = 1'b1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(1);
    start_i = 1; tick(1); start_i = 0; m_sda = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(2);
    scl_rise_i = 1; tick(1); scl_rise_i = 0; tick(2);
    m_sda = 1'b1; stop_i = 1; tick(1); stop_i = 0; tick(4);
  endtask

  task automatic t_reset();
    chk("R4 reset sda_oe", sda_oe, 0);
    chk("R5 reset wr_we", wr_we, 0);
    chk("R5 reset commit", wr_commit, 0);
    chk("R7 reset rd_addr", rd_addr, 0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte({4'b1011, SEL, 1'b0}, a); chk("R1 wrong type no ack", a, 0);
    send_byte(8'hA0, a);                chk("R1 ignored until start", a, 0);
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, a); chk("R1 wrong select no ack", a, 0);
    bus_stop();
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a); chk("R2 write device ack", a, 1);
    send_byte(8'hE1, a);                chk("R3 high byte ack", a, 1);
    send_byte(8'h23, a);                chk("R3 low byte ack", a, 1);
    send_byte(8'h5A, a);                chk("R5 data ack", a, 1);
    chk("R4 released after ack slot", sda_oe, 0);
    bus_stop();
    chk("R5 one write strobe", lg_n, 1);
    chk("R3 masked address", lg_a[0], 13'h0123);
    chk("R5 write data", lg_d[0], 8'h5A);
    chk("R5 one commit", commit_n, 1);
  endtask

  task automatic t_page_write();
    logic a;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a);
    send_byte(8'h00, a); send_byte(8'h3E, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk("R6 third byte ack", a, 1);
    bus_stop();
    chk("R6 strobes", lg_n, 4);
    chk("R6 addr0", lg_a[1], 13'h003E);
    chk("R6 addr1", lg_a[2], 13'h003F);
    chk("R6 page wrap", lg_a[3], 13'h0020);
    chk("R6 data wrap", lg_d[3], 8'h33);
    chk("R5 second commit", commit_n, 2);
  endtask

  task automatic t_cur_read(input logic [12:0] exp_a, input string tag);
    logic a; logic [7:0] d;
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, a); chk({tag, " read device ack"}, a, 1);
    recv_byte(d, 1'b0);                 chk({tag, " current-address data"}, d, mem_f(exp_a));
    bus_stop();
  endtask

  task automatic t_rand_seq();
    logic a, s; logic [7:0] d;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a);
    send_byte(8'h1F, a); send_byte(8'hFE, a);
    bus_start();
    send_byte({4'b1010, SEL, 1'b1}, a); chk("R8 repeated start ack", a, 1);
    recv_byte(d, 1'b1); chk("R8 random read data", d, mem_f(13'h1FFE));
    recv_byte(d, 1'b1); chk("R9 sequential next", d, mem_f(13'h1FFF));
    recv_byte(d, 1'b0); chk("R9 wrap to zero", d, mem_f(13'h0000));
    bit_io(1'b1, s); chk("R10 released after nack", s, 1);
    bit_io(1'b1, s); chk("R10 still released", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_wp();
    logic a;
    wp_i = 1;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a); chk("R11 device ack under wp", a, 1);
    send_byte(8'h02, a);                chk("R11 high ack under wp", a, 1);
    send_byte(8'h10, a);                chk("R11 low ack under wp", a, 1);
    send_byte(8'h77, a);                chk("R11 data nack under wp", a, 0);
    bus_stop();
    chk("R11 no strobe", lg_n, 4);
    chk("R11 no commit", commit_n, 2);
    wp_i = 0;
  endtask

  task automatic t_busy();
    logic a;
    busy_i = 1;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a); chk("R12 busy no ack", a, 0);
    bus_stop();
    busy_i = 0;
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a); chk("R12 ack after busy", a, 1);
    bus_stop();
    chk("R5 no commit without data", commit_n, 2);
  endtask

  task automatic t_abort();
    logic a, s;
    bus_start();
    bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s); bit_io(1'b0, s);
    bus_start();
    send_byte({4'b1010, SEL, 1'b0}, a); chk("R14 header after mid-byte start", a, 1);
    send_byte(8'h00, a); send_byte(8'h40, a);
    bit_io(1'b1, s); bit_io(1'b1, s); bit_io(1'b0, s);
    bus_stop();
    chk("R14 partial byte not written", lg_n, 4);
    chk("R14 no commit on partial", commit_n, 2);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(2);
    t_reset();
    t_bad_addr();
    t_byte_write();
    t_page_write();
    t_cur_read(13'h0021, "R7 after write");
    t_rand_seq();
    t_cur_read(13'h0001, "R7 after read");
    t_wp();
    t_busy();
    t_abort();
    t_cur_read(13'h0040, "R14 loaded address");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule